// File: doc/BRIEF.md
# Multi-mode power gating controller

This controller drives the two gating controls of a power-switched storage region. The first control, `main_ctl`, enables the main footer switch bank when high. The second, `ret_ctl`, belongs to a parallel retention switch that conducts while its control is low. The two bits together form a gating code. Three codes are operating modes: full-power active, data-holding retention, and cut-off, which removes all leakage paths and loses the stored contents. A fourth code, intermediate, turns on both controls. It is used only while the region moves from one operating mode to another, and it holds for a set number of cycles so that ground bounce stays small.

A power manager sends a one-cycle request naming a target mode. The controller ignores a request for the mode it is already in. It starts a transition for any other target, and it holds a request that arrives during a transition until that transition has finished. The controller reports the present mode and a busy flag. It also keeps a data-lost flag: the flag is set when the region enters cut-off, and it clears only after the region is back in active mode and the client acknowledges that the contents have been restored.

Top module: `pgate_mode_ctrl`

## Requirements
- R1: While reset is asserted, and immediately after it is released, the controller is in cut-off: `main_ctl`=0, `ret_ctl`=1, `cur_mode`=2, `data_lost`=1 and `busy`=0.
- R2: The gating code {`main_ctl`,`ret_ctl`} is 2'b10 in active, 2'b00 in retention, 2'b01 in cut-off and 2'b11 in intermediate.
- R3: A legal request for a target that differs from the current steady mode is sampled on a clock edge. From that edge the intermediate code is shown for exactly DWELL_CYCLES cycles (default 4). After that, the code of the target is shown.
- R4: The gating code never changes directly from one operating code to a different operating code. Every such change passes through 2'b11.
- R5: A request for the current steady mode while nothing is pending has no effect, and so does a request with `req_mode`=3. The code, `cur_mode` and `busy` stay unchanged.
- R6: A legal request sampled during intermediate is stored. If several arrive, the latest one is kept. The stored request is served on the first edge after the target is reached, so the target code is seen for one cycle before the next intermediate period. A stored request equal to the mode just reached is dropped.
- R7: `busy` is 1 whenever the code is intermediate, and also in the steady cycle while a stored request waits. Otherwise it is 0.
- R8: `data_lost` becomes 1 on the edge where cut-off is entered, and it stays 1 for the whole time the region is in cut-off.
- R9: `data_lost` clears only on an edge where the mode is active and `restore_ack` is 1. An acknowledge received in any other mode is ignored, and retention leaves the flag unchanged.
- R10: `cur_mode` encodes 0 for active, 1 for retention, 2 for cut-off and 3 for intermediate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_mode | input | 2 | Requested target mode: 0 active, 1 retention, 2 cut-off, 3 ignored |
| restore_ack | input | 1 | Client has restored the contents; honoured only in active |
| main_ctl | output | 1 | Main switch bank enable, high conducts |
| ret_ctl | output | 1 | Retention switch control, low conducts |
| cur_mode | output | 2 | Current mode, 3 while in intermediate |
| busy | output | 1 | Transition running or a request waiting |
| data_lost | output | 1 | Stored contents are not valid |

## Verification
The hardest case to reach is a request that has been stored and is then served right behind the transition that stored it. The stimulus sends three requests on consecutive edges: the first starts a transition and the next two arrive during intermediate, so the last one must win. The bench then confirms that the reached mode appears for exactly one cycle with `busy` still high, and that a second intermediate period of full length follows. A separate pass repeats the target during a transition to show that a stored request equal to the reached mode is dropped. A monitor logs every code change together with how long the previous code was held. It compares this log against an expected sequence queued by the driver, which catches both a direct jump between operating codes and any wrong dwell length.

// File: rtl/pgate_pkg.sv
package pgate_pkg;

   typedef enum logic [1:0] {
      MODE_ACT = 2'd0,
      MODE_RET = 2'd1,
      MODE_CUT = 2'd2,
      MODE_MID = 2'd3
   } pg_mode_e;

   // {main switch enable, retention switch control (low conducts)}
   function automatic logic [1:0] pg_code(pg_mode_e m);
      case (m)
         MODE_ACT: pg_code = 2'b10;
         MODE_RET: pg_code = 2'b00;
         MODE_CUT: pg_code = 2'b01;
         default:  pg_code = 2'b11;
      endcase
   endfunction

endpackage

// File: rtl/pgate_dwell_timer.sv
module pgate_dwell_timer #(
   parameter int DWELL_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic run,
   output logic done
);
   localparam int CNT_W = (DWELL_CYCLES > 1) ? $clog2(DWELL_CYCLES) : 1;

   generate
      if (DWELL_CYCLES < 1) begin : g_bad_dwell
         $error("pgate_dwell_timer: DWELL_CYCLES must be at least 1");
      end

      if (DWELL_CYCLES == 1) begin : g_single
         assign done = 1'b1;
      end else begin : g_count
         localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(DWELL_CYCLES - 1);
         logic [CNT_W-1:0] cnt;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (load) begin
               cnt <= LOAD_VAL;
            end else if (run && cnt != '0) begin
               cnt <= cnt - 1'b1;
            end
         end

         assign done = (cnt == '0);
      end
   endgenerate

endmodule

// File: rtl/pgate_req_hold.sv
module pgate_req_hold
   import pgate_pkg::*;
#(
   parameter bit LAST_WINS = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     capture,
   input  pg_mode_e cap_mode,
   input  logic     consume,
   output logic     pend_vld,
   output pg_mode_e pend_mode
);
   generate
      if (LAST_WINS) begin : g_last
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pend_vld  <= 1'b0;
               pend_mode <= MODE_CUT;
            end else if (capture) begin
               pend_vld  <= 1'b1;
               pend_mode <= cap_mode;
            end else if (consume) begin
               pend_vld  <= 1'b0;
            end
         end
      end else begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pend_vld  <= 1'b0;
               pend_mode <= MODE_CUT;
            end else if (capture && !pend_vld) begin
               pend_vld  <= 1'b1;
               pend_mode <= cap_mode;
            end else if (consume) begin
               pend_vld  <= 1'b0;
            end
         end
      end
   endgenerate

   // R6: a stored request is never taken while a steady-state consume is active
   p_hold_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(capture && consume));

endmodule

// File: rtl/pgate_lost_flag.sv
module pgate_lost_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic enter_cut,
   input  logic in_active,
   input  logic restore_ack,
   output logic data_lost
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_lost <= 1'b1;
      end else if (enter_cut) begin
         data_lost <= 1'b1;
      end else if (in_active && restore_ack) begin
         data_lost <= 1'b0;
      end
   end

   p_clear_only_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(data_lost) |-> ($past(in_active) && $past(restore_ack)));

endmodule

// File: rtl/pgate_mode_ctrl.sv
module pgate_mode_ctrl
   import pgate_pkg::*;
#(
   parameter int DWELL_CYCLES = 4,
   parameter bit LAST_WINS    = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic [1:0] req_mode,
   input  logic       restore_ack,
   output logic       main_ctl,
   output logic       ret_ctl,
   output logic [1:0] cur_mode,
   output logic       busy,
   output logic       data_lost
);
   pg_mode_e cur_q, tgt_q;
   pg_mode_e req_m, pend_mode, cand_mode;
   logic     legal_req, in_mid, pend_vld, cand_vld;
   logic     start, capture, consume, tmr_done, enter_cut;

   assign req_m     = pg_mode_e'(req_mode);
   assign legal_req = req_valid && (req_m != MODE_MID);
   assign in_mid    = (cur_q == MODE_MID);

   // new request beats a stored one in the steady cycle
   assign cand_vld  = legal_req || pend_vld;
   assign cand_mode = legal_req ? req_m : pend_mode;

   assign start     = !in_mid && cand_vld && (cand_mode != cur_q);
   assign capture   = in_mid && legal_req;
   assign consume   = !in_mid && pend_vld;
   assign enter_cut = in_mid && tmr_done && (tgt_q == MODE_CUT);

   pgate_req_hold #(.LAST_WINS(LAST_WINS)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture   (capture),
      .cap_mode  (req_m),
      .consume   (consume),
      .pend_vld  (pend_vld),
      .pend_mode (pend_mode)
   );

   pgate_dwell_timer #(.DWELL_CYCLES(DWELL_CYCLES)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (start),
      .run   (in_mid),
      .done  (tmr_done)
   );

   pgate_lost_flag u_lost (
      .clk         (clk),
      .rst_n       (rst_n),
      .enter_cut   (enter_cut),
      .in_active   (cur_q == MODE_ACT),
      .restore_ack (restore_ack),
      .data_lost   (data_lost)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q <= MODE_CUT;
         tgt_q <= MODE_CUT;
      end else if (start) begin
         cur_q <= MODE_MID;
         tgt_q <= cand_mode;
      end else if (in_mid && tmr_done) begin
         cur_q <= tgt_q;
      end
   end

   assign {main_ctl, ret_ctl} = pg_code(cur_q);
   assign cur_mode            = cur_q;
   assign busy                = in_mid || pend_vld;

   // checker-only run length of the intermediate code
   logic [31:0] mid_run;
   always_ff @(posedge clk) begin
      if (!rst_n)      mid_run <= '0;
      else if (in_mid) mid_run <= mid_run + 1'b1;
      else             mid_run <= '0;
   end

   p_no_direct_jump_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ({main_ctl, ret_ctl} != $past({main_ctl, ret_ctl})) |->
         ({main_ctl, ret_ctl} == 2'b11 || $past({main_ctl, ret_ctl}) == 2'b11));

   p_mid_dwell_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(in_mid) && !in_mid) |-> (mid_run == 32'(DWELL_CYCLES)));

   p_lost_in_cut_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode == 2'd2) |-> data_lost);

   p_busy_mid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode == 2'd3) |-> busy);

   p_ignore_same_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_mid && !pend_vld && req_valid && (req_m == cur_q || req_m == MODE_MID))
         |=> $stable(cur_mode));

endmodule

// File: tb/pgate_mode_ctrl_test.sv
module pgate_mode_ctrl_test;
   localparam int DW = 4;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       req_valid;
   logic [1:0] req_mode;
   logic       restore_ack;
   logic       main_ctl, ret_ctl, busy, data_lost;
   logic [1:0] cur_mode;

   int n_chk  = 0;
   int n_fail = 0;

   typedef struct {
      logic [1:0] code;
      int         prev_run;
   } item_t;
   item_t exp_q[$];

   always #4 clk = ~clk;

   pgate_mode_ctrl #(.DWELL_CYCLES(DW)) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_mode    (req_mode),
      .restore_ack (restore_ack),
      .main_ctl    (main_ctl),
      .ret_ctl     (ret_ctl),
      .cur_mode    (cur_mode),
      .busy        (busy),
      .data_lost   (data_lost)
   );

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic push(logic [1:0] c, int pr);
      item_t it;
      it.code = c;
      it.prev_run = pr;
      exp_q.push_back(it);
   endtask

   task automatic request(logic [1:0] m);
      req_valid = 1'b1;
      req_mode  = m;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic ack_pulse();
      restore_ack = 1'b1;
      @(negedge clk);
      restore_ack = 1'b0;
   endtask

   task automatic settle(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // monitor: every code change is compared with the queued expectation
   logic [1:0] last_code;
   int         run_len;
   always @(negedge clk) begin
      if (!rst_n) begin
         last_code = 2'b01;
         run_len   = 0;
      end else if ({main_ctl, ret_ctl} == last_code) begin
         run_len++;
      end else begin
         n_chk++;
         if (last_code != 2'b11 && {main_ctl, ret_ctl} != 2'b11) begin
            n_fail++;
            $display("FAIL R4: direct jump actual %b expected via 11 from %b",
                     {main_ctl, ret_ctl}, last_code);
         end
         if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL R3: unexpected change actual %b expected none",
                     {main_ctl, ret_ctl});
         end else begin
            item_t it;
            it = exp_q.pop_front();
            check("R3 code", {main_ctl, ret_ctl}, it.code);
            if (it.prev_run >= 0) check("R3 hold length", run_len, it.prev_run);
         end
         last_code = {main_ctl, ret_ctl};
         run_len   = 1;
      end
   end

   initial begin
      #(200000 * 8);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_mode = 2'd0; restore_ack = 1'b0;
      settle(3);
      check("R1 main_ctl", main_ctl, 0);
      check("R1 ret_ctl", ret_ctl, 1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 cur_mode", cur_mode, 2);
      check("R1 data_lost", data_lost, 1);
      check("R1 busy", busy, 0);

      // cut-off -> active, ack during intermediate ignored
      push(2'b11, -1); push(2'b10, DW);
      request(2'd0);
      check("R7 busy in intermediate", busy, 1);
      check("R10 cur_mode intermediate", cur_mode, 3);
      check("R2 intermediate code", {main_ctl, ret_ctl}, 2'b11);
      ack_pulse();
      settle(DW - 1);
      check("R2 active code", {main_ctl, ret_ctl}, 2'b10);
      check("R10 cur_mode active", cur_mode, 0);
      check("R9 ack in intermediate ignored", data_lost, 1);
      check("R7 busy idle", busy, 0);
      ack_pulse();
      check("R9 cleared in active", data_lost, 0);

      // R5: same-mode and mode-3 requests ignored
      request(2'd0);
      settle(2);
      check("R5 same mode cur_mode", cur_mode, 0);
      check("R5 same mode busy", busy, 0);
      request(2'd3);
      settle(2);
      check("R5 mode 3 cur_mode", cur_mode, 0);
      check("R5 mode 3 busy", busy, 0);

      // active -> retention
      push(2'b11, -1); push(2'b00, DW);
      request(2'd1);
      settle(DW);
      check("R2 retention code", {main_ctl, ret_ctl}, 2'b00);
      check("R10 cur_mode retention", cur_mode, 1);
      check("R9 retention keeps flag", data_lost, 0);

      // retention -> cut-off
      push(2'b11, -1); push(2'b01, DW);
      request(2'd2);
      settle(DW - 1);
      check("R8 not set before entry", data_lost, 0);
      @(negedge clk);
      check("R2 cut-off code", {main_ctl, ret_ctl}, 2'b01);
      check("R8 set on cut-off entry", data_lost, 1);
      ack_pulse();
      check("R9 ack in cut-off ignored", data_lost, 1);

      // R6: two requests stored during intermediate, latest wins
      push(2'b11, -1); push(2'b10, DW); push(2'b11, 1); push(2'b01, DW);
      request(2'd0);
      request(2'd1);
      request(2'd2);
      @(negedge clk);
      check("R6 still intermediate", cur_mode, 3);
      @(negedge clk);
      check("R6 target reached one cycle", cur_mode, 0);
      check("R7 busy with stored request", busy, 1);
      settle(DW + 1);
      check("R6 latest request served", cur_mode, 2);
      check("R7 busy after serve", busy, 0);
      check("R8 flag after second cut-off", data_lost, 1);

      // R6: stored request equal to reached mode dropped
      push(2'b11, -1); push(2'b10, DW);
      request(2'd0);
      request(2'd0);
      settle(DW - 1);
      check("R6 reached active", cur_mode, 0);
      @(negedge clk);
      check("R6 equal request dropped busy", busy, 0);
      settle(DW);
      check("R6 equal request dropped mode", cur_mode, 0);

      // R9: retention round trip after restore keeps flag clear
      ack_pulse();
      check("R9 cleared again", data_lost, 0);
      push(2'b11, -1); push(2'b00, DW);
      request(2'd1);
      settle(DW);
      push(2'b11, -1); push(2'b10, DW);
      request(2'd0);
      settle(DW);
      check("R9 retention round trip", data_lost, 0);
      check("R10 back in active", cur_mode, 0);

      settle(3);
      check("R3 all expected changes seen", exp_q.size(), 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end
endmodule